// File: doc/BRIEF.md
# Chained Directory Coherence Controller

This block is the directory for a small shared memory. It does not keep a presence vector for each line. Instead it records the sharers of a line as a singly linked list. The directory stores only the head of the list. Each cache keeps a pointer to the next sharer, or a termination code if it is the last one. The per-cache pointer registers are modelled inside the block, so the block can be used on its own.

Processors issue read or write requests on N ports. Each port uses a valid/ready handshake. When several ports request at once, the lowest-numbered port wins. A read returns the line data together with a link value. The reader then becomes the new head of the chain. A write to a line that has sharers starts an invalidation walk. The walk begins at the head and advances one sharer per clock cycle, and each sharer it visits drops its copy. Write permission is granted only after the sharer holding the termination code has been visited, which acts as its acknowledgement. While a walk is running, every port sees ready low. The `inv_valid`/`inv_port` outputs show which sharer is visited in each cycle.

The controller has two states. `ST_IDLE` accepts one request per cycle. A read, or a write to a line with no sharers, completes with a registered response and stays in `ST_IDLE`. A write to a line that has sharers moves to `ST_WALK`. `ST_WALK` remains in `ST_WALK` while the visited sharer's next pointer is another sharer. It returns to `ST_IDLE` and issues the grant when the visited sharer holds the termination code.

Top module: `chain_dir_ctrl`

## Requirements
- R1: After reset, `rsp_valid` and `inv_valid` are low, `req_ready` is all zeros while no request is valid, and every line reads as zero data.
- R2: A read of a line with no sharers responds in the cycle after acceptance with the line data and `rsp_link` equal to NPROC (the termination code, 4 by default). `rsp_port` is the reader and `rsp_write` is 0.
- R3: A read by a processor that is not yet a sharer of a line that has sharers returns `rsp_link` equal to the current head port number, and the reader becomes the new head.
- R4: A read by a processor that is already a valid sharer returns its existing link and leaves the chain unchanged.
- R5: A write to a line with no sharers is granted in the cycle after acceptance. The grant has `rsp_write`=1 and `rsp_link` equal to the termination code, and `inv_valid` stays low.
- R6: A write to a shared line drives `inv_valid` for consecutive cycles, one per sharer. `inv_port` follows the chain from the head to the terminating sharer. The grant appears in the cycle after the terminating sharer's hop.
- R7: After a write grant, the writer is the only sharer and the chain head. A later read by another processor gets `rsp_link` equal to the writer, and a former sharer is treated as a new reader.
- R8: Data written at a grant is returned by later reads of that line.
- R9: `req_ready` stays all zeros for the whole walk. A request held valid during the walk is accepted in the cycle in which the grant response is visible.
- R10: When several ports request in the same cycle, only the lowest-numbered valid port sees `req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NPROC | Request valid, one bit per port |
| req_write | input | NPROC | 1 = write request, 0 = read |
| req_line | input | NPROC*LNW | Line index per port, port p at bits p*LNW |
| req_wdata | input | NPROC*DW | Write data per port, port p at bits p*DW |
| req_ready | output | NPROC | Request accepted in this cycle |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_write | output | 1 | Response is a write grant |
| rsp_port | output | PW | Port being answered |
| rsp_data | output | DW | Line data (written data on a grant) |
| rsp_link | output | LW | Next sharer, or NPROC as termination |
| inv_valid | output | 1 | Invalidation hop in this cycle |
| inv_port | output | PW | Sharer visited by the hop |

## Verification
The assertions assume that every requester keeps valid, write, line and data stable until it sees ready. This assumption is what keeps the chain free of repeats, so every hop lands on a valid sharer. The bench raises a request at the falling edge and holds it until ready is sampled high. It lowers the request only after the accepting edge, and it keeps a stalled request held through the whole walk. Line indices always stay within the line count, so the directory is never addressed out of range.

// File: rtl/chain_dir_pkg.sv
package chain_dir_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } dir_state_e;
endpackage

// File: rtl/chain_dir_arb.sv
module chain_dir_arb #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    logic [N-1:0] blocked;

    assign blocked[0] = 1'b0;
    generate
        for (genvar i = 1; i < N; i++) begin : g_prefix
            assign blocked[i] = blocked[i-1] | req[i-1];
        end
    endgenerate

    assign gnt = req & ~blocked;
endmodule

// File: rtl/chain_dir_links.sv
module chain_dir_links #(
    parameter int NPROC  = 4,
    parameter int NLINES = 8,
    parameter int PW     = 2,
    parameter int LNW    = 3,
    parameter int LW     = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [PW-1:0]  rd_port,
    input  logic [LNW-1:0] rd_line,
    output logic           rd_vld,
    output logic [LW-1:0]  rd_nxt,
    input  logic [PW-1:0]  wk_port,
    input  logic [LNW-1:0] wk_line,
    output logic [LW-1:0]  wk_nxt,
    input  logic           set_en,
    input  logic [PW-1:0]  set_port,
    input  logic [LNW-1:0] set_line,
    input  logic [LW-1:0]  set_nxt,
    input  logic           clr_en,
    input  logic [PW-1:0]  clr_port,
    input  logic [LNW-1:0] clr_line
);
    logic          vld_q [NPROC][NLINES];
    logic [LW-1:0] nxt_q [NPROC][NLINES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NPROC; p++) begin
                for (int l = 0; l < NLINES; l++) begin
                    vld_q[p][l] <= 1'b0;
                    nxt_q[p][l] <= LW'(NPROC);
                end
            end
        end else begin
            if (clr_en) vld_q[clr_port][clr_line] <= 1'b0;
            if (set_en) begin
                vld_q[set_port][set_line] <= 1'b1;
                nxt_q[set_port][set_line] <= set_nxt;
            end
        end
    end

    assign rd_vld = vld_q[rd_port][rd_line];
    assign rd_nxt = nxt_q[rd_port][rd_line];
    assign wk_nxt = nxt_q[wk_port][wk_line];

    AST_HOP_ON_SHARER: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |-> vld_q[clr_port][clr_line]); // R6
endmodule

// File: rtl/chain_dir_dirmem.sv
module chain_dir_dirmem #(
    parameter int NLINES = 8,
    parameter int DW     = 16,
    parameter int PW     = 2,
    parameter int LNW    = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [LNW-1:0] rd_line,
    output logic [PW-1:0]  head,
    output logic           head_vld,
    output logic [DW-1:0]  data,
    input  logic           upd_en,
    input  logic [LNW-1:0] upd_line,
    input  logic [PW-1:0]  upd_head,
    input  logic           upd_dirty,
    input  logic           wr_en,
    input  logic [DW-1:0]  wr_data
);
    logic [PW-1:0] head_q  [NLINES];
    logic          hvld_q  [NLINES];
    logic          dirty_q [NLINES];
    logic [DW-1:0] mem_q   [NLINES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l < NLINES; l++) begin
                head_q[l]  <= '0;
                hvld_q[l]  <= 1'b0;
                dirty_q[l] <= 1'b0;
                mem_q[l]   <= '0;
            end
        end else begin
            if (upd_en) begin
                head_q[upd_line]  <= upd_head;
                hvld_q[upd_line]  <= 1'b1;
                dirty_q[upd_line] <= upd_dirty;
            end
            if (wr_en) mem_q[upd_line] <= wr_data;
        end
    end

    assign head     = head_q[rd_line];
    assign head_vld = hvld_q[rd_line];
    assign data     = mem_q[rd_line];

    AST_WRITE_MARKS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (dirty_q[$past(upd_line)] && hvld_q[$past(upd_line)])); // R7
endmodule

// File: rtl/chain_dir_ctrl.sv
module chain_dir_ctrl
    import chain_dir_pkg::*;
#(
    parameter int NPROC  = 4,
    parameter int NLINES = 8,
    parameter int DW     = 16,
    localparam int PW    = (NPROC > 1) ? $clog2(NPROC) : 1,
    localparam int LW    = $clog2(NPROC + 1),
    localparam int LNW   = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NPROC-1:0]      req_valid,
    input  logic [NPROC-1:0]      req_write,
    input  logic [NPROC*LNW-1:0]  req_line,
    input  logic [NPROC*DW-1:0]   req_wdata,
    output logic [NPROC-1:0]      req_ready,
    output logic                  rsp_valid,
    output logic                  rsp_write,
    output logic [PW-1:0]         rsp_port,
    output logic [DW-1:0]         rsp_data,
    output logic [LW-1:0]         rsp_link,
    output logic                  inv_valid,
    output logic [PW-1:0]         inv_port
);
    localparam logic [LW-1:0] CT = LW'(NPROC);

    dir_state_e     state_q, state_d;
    logic [PW-1:0]  cur_q, cur_d;
    logic [PW-1:0]  w_port_q, w_port_d;
    logic [LNW-1:0] w_line_q, w_line_d;
    logic [DW-1:0]  w_data_q, w_data_d;

    logic [NPROC-1:0] gnt;
    logic           accept;
    logic [PW-1:0]  sel_idx;
    logic [LNW-1:0] sel_line;
    logic [DW-1:0]  sel_wdata;
    logic           sel_write;

    logic [LNW-1:0] mem_line;
    logic [PW-1:0]  head;
    logic           head_vld;
    logic [DW-1:0]  mem_data;
    logic           rd_vld;
    logic [LW-1:0]  rd_nxt;
    logic [LW-1:0]  wk_nxt;

    logic           set_en, clr_en, upd_en, upd_dirty, wr_en;
    logic [PW-1:0]  set_port, clr_port, upd_head;
    logic [LNW-1:0] set_line, clr_line, upd_line;
    logic [LW-1:0]  set_nxt;
    logic [DW-1:0]  wr_data;

    logic           rs_en, rs_write;
    logic [PW-1:0]  rs_port;
    logic [DW-1:0]  rs_data;
    logic [LW-1:0]  rs_link;

    chain_dir_arb #(.N(NPROC)) u_arb (.req(req_valid), .gnt(gnt));

    assign req_ready = (state_q == ST_IDLE) ? gnt : '0;
    assign accept    = (state_q == ST_IDLE) && (|req_valid);

    always_comb begin
        sel_idx = '0;
        for (int i = 0; i < NPROC; i++) begin
            if (gnt[i]) sel_idx = PW'(i);
        end
    end

    assign sel_line  = req_line[sel_idx*LNW +: LNW];
    assign sel_wdata = req_wdata[sel_idx*DW +: DW];
    assign sel_write = req_write[sel_idx];

    chain_dir_dirmem #(.NLINES(NLINES), .DW(DW), .PW(PW), .LNW(LNW)) u_dir (
        .clk(clk), .rst_n(rst_n), .rd_line(mem_line),
        .head(head), .head_vld(head_vld), .data(mem_data),
        .upd_en(upd_en), .upd_line(upd_line), .upd_head(upd_head),
        .upd_dirty(upd_dirty), .wr_en(wr_en), .wr_data(wr_data)
    );

    chain_dir_links #(.NPROC(NPROC), .NLINES(NLINES), .PW(PW), .LNW(LNW), .LW(LW)) u_links (
        .clk(clk), .rst_n(rst_n),
        .rd_port(sel_idx), .rd_line(sel_line), .rd_vld(rd_vld), .rd_nxt(rd_nxt),
        .wk_port(cur_q), .wk_line(w_line_q), .wk_nxt(wk_nxt),
        .set_en(set_en), .set_port(set_port), .set_line(set_line), .set_nxt(set_nxt),
        .clr_en(clr_en), .clr_port(clr_port), .clr_line(clr_line)
    );

    // Next state and per-cycle control
    always_comb begin
        state_d  = state_q;
        cur_d    = cur_q;
        w_port_d = w_port_q;
        w_line_d = w_line_q;
        w_data_d = w_data_q;
        mem_line = sel_line;
        set_en   = 1'b0;  set_port = sel_idx;  set_line = sel_line;  set_nxt = CT;
        clr_en   = 1'b0;  clr_port = cur_q;    clr_line = w_line_q;
        upd_en   = 1'b0;  upd_line = sel_line; upd_head = sel_idx;   upd_dirty = 1'b0;
        wr_en    = 1'b0;  wr_data  = sel_wdata;
        rs_en    = 1'b0;  rs_write = 1'b0;     rs_port  = sel_idx;
        rs_data  = mem_data;
        rs_link  = CT;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && !sel_write) begin
                    rs_en = 1'b1;
                    if (rd_vld) begin
                        rs_link = rd_nxt;
                    end else begin
                        rs_link = head_vld ? LW'(head) : CT;
                        set_en  = 1'b1;
                        set_nxt = rs_link;
                        upd_en  = 1'b1;
                    end
                end else if (accept && !head_vld) begin
                    set_en    = 1'b1;
                    upd_en    = 1'b1;
                    upd_dirty = 1'b1;
                    wr_en     = 1'b1;
                    rs_en     = 1'b1;
                    rs_write  = 1'b1;
                    rs_data   = sel_wdata;
                end else if (accept) begin
                    w_port_d = sel_idx;
                    w_line_d = sel_line;
                    w_data_d = sel_wdata;
                    cur_d    = head;
                    state_d  = ST_WALK;
                end
            end
            ST_WALK: begin
                mem_line = w_line_q;
                clr_en   = 1'b1;
                if (wk_nxt == CT) begin
                    set_en    = 1'b1;
                    set_port  = w_port_q;
                    set_line  = w_line_q;
                    upd_en    = 1'b1;
                    upd_line  = w_line_q;
                    upd_head  = w_port_q;
                    upd_dirty = 1'b1;
                    wr_en     = 1'b1;
                    wr_data   = w_data_q;
                    rs_en     = 1'b1;
                    rs_write  = 1'b1;
                    rs_port   = w_port_q;
                    rs_data   = w_data_q;
                    state_d   = ST_IDLE;
                end else begin
                    cur_d = wk_nxt[PW-1:0];
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cur_q    <= '0;
            w_port_q <= '0;
            w_line_q <= '0;
            w_data_q <= '0;
        end else begin
            state_q  <= state_d;
            cur_q    <= cur_d;
            w_port_q <= w_port_d;
            w_line_q <= w_line_d;
            w_data_q <= w_data_d;
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_write <= 1'b0;
            rsp_port  <= '0;
            rsp_data  <= '0;
            rsp_link  <= CT;
        end else begin
            rsp_valid <= rs_en;
            rsp_write <= rs_write;
            rsp_port  <= rs_port;
            rsp_data  <= rs_data;
            rsp_link  <= rs_link;
        end
    end

    assign inv_valid = (state_q == ST_WALK);
    assign inv_port  = cur_q;

    AST_READY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready)); // R10
    AST_STALL_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> (req_ready == '0)); // R9
    AST_GRANT_ENDS_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(inv_valid) |-> (rsp_valid && rsp_write)); // R6
    AST_GRANT_TERMINATES: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_write) |-> (rsp_link == CT)); // R5
endmodule

// File: tb/sim_chain_dir_ctrl.sv
module sim_chain_dir_ctrl;
    localparam int NPROC = 4;
    localparam int NLINES = 8;
    localparam int DW = 16;
    localparam int PW = 2;
    localparam int LW = 3;
    localparam int LNW = 3;
    localparam logic [LW-1:0] CT = 3'd4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NPROC-1:0] req_valid = '0;
    logic [NPROC-1:0] req_write = '0;
    logic [NPROC*LNW-1:0] req_line = '0;
    logic [NPROC*DW-1:0] req_wdata = '0;
    logic [NPROC-1:0] req_ready;
    logic rsp_valid, rsp_write, inv_valid;
    logic [PW-1:0] rsp_port, inv_port;
    logic [DW-1:0] rsp_data;
    logic [LW-1:0] rsp_link;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    chain_dir_ctrl #(.NPROC(NPROC), .NLINES(NLINES), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_line(req_line), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_write(rsp_write), .rsp_port(rsp_port),
        .rsp_data(rsp_data), .rsp_link(rsp_link),
        .inv_valid(inv_valid), .inv_port(inv_port)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drive(input int p, input bit wr, input int line, input int data);
        req_valid[p] = 1'b1;
        req_write[p] = wr;
        req_line[p*LNW +: LNW] = LNW'(line);
        req_wdata[p*DW +: DW] = DW'(data);
    endtask

    // Returns at the falling edge after the accepting edge (+1)
    task automatic issue(input int p, input bit wr, input int line, input int data);
        @(negedge clk);
        drive(p, wr, line, data);
        #1;
        while (!req_ready[p]) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        req_valid[p] = 1'b0;
        #1;
    endtask

    task automatic chk_rsp(input string tag, input int p, input bit wr, input int data, input int link);
        chk(rsp_valid == 1'b1, {tag, " rsp_valid"}, int'(rsp_valid), 1);
        chk(rsp_port == PW'(p), {tag, " rsp_port"}, int'(rsp_port), p);
        chk(rsp_write == wr, {tag, " rsp_write"}, int'(rsp_write), int'(wr));
        chk(rsp_data == DW'(data), {tag, " rsp_data"}, int'(rsp_data), data);
        chk(rsp_link == LW'(link), {tag, " rsp_link"}, int'(rsp_link), link);
    endtask

    task automatic read_chk(input string tag, input int p, input int line, input int data, input int link);
        issue(p, 1'b0, line, 0);
        chk_rsp(tag, p, 1'b0, data, link);
    endtask

    task automatic write_walk(input string tag, input int p, input int line, input int data,
                              input int nh, input int h0, input int h1, input int h2, input int h3);
        int exp_h[4];
        int n;
        exp_h = '{h0, h1, h2, h3};
        n = 0;
        issue(p, 1'b1, line, data);
        while (!rsp_valid && n < 8) begin
            chk(inv_valid == 1'b1, {tag, " inv_valid"}, int'(inv_valid), 1);
            if (n < 4) chk(int'(inv_port) == exp_h[n], {tag, " hop order"}, int'(inv_port), exp_h[n]);
            n++;
            @(negedge clk);
            #1;
        end
        chk(n == nh, {tag, " hop count"}, n, nh);
        chk(inv_valid == 1'b0, {tag, " walk ended"}, int'(inv_valid), 0);
        chk_rsp({tag, " grant"}, p, 1'b1, data, int'(CT));
    endtask

    task automatic t_reset();
        @(negedge clk);
        #1;
        chk(rsp_valid == 1'b0, "R1 rsp_valid", int'(rsp_valid), 0);
        chk(inv_valid == 1'b0, "R1 inv_valid", int'(inv_valid), 0);
        chk(req_ready == '0, "R1 req_ready", int'(req_ready), 0);
    endtask

    task automatic t_chain_build();
        read_chk("R2 R1 first read", 0, 2, 0, 4);
        read_chk("R3 second reader", 1, 2, 0, 0);
        read_chk("R3 third reader", 2, 2, 0, 1);
    endtask

    task automatic t_resharer();
        read_chk("R4 reread by sharer", 1, 2, 0, 0);
        read_chk("R4 head unchanged", 3, 2, 0, 2);
    endtask

    task automatic t_walk_and_after();
        write_walk("R6 four-hop walk", 1, 2, 16'hBEEF, 4, 3, 2, 1, 0);
        read_chk("R7 R8 read after grant", 0, 2, 16'hBEEF, 1);
        read_chk("R7 former sharer rejoins", 2, 2, 16'hBEEF, 0);
    endtask

    task automatic t_unshared_write();
        issue(2, 1'b1, 5, 16'h1234);
        chk(inv_valid == 1'b0, "R5 no walk", int'(inv_valid), 0);
        chk_rsp("R5 direct grant", 2, 1'b1, 16'h1234, 4);
        read_chk("R8 read written line", 3, 5, 16'h1234, 2);
        write_walk("R6 writer in chain", 3, 5, 16'h0077, 2, 3, 2, 0, 0);
    endtask

    task automatic t_stall();
        int n;
        n = 0;
        @(negedge clk);
        drive(0, 1'b1, 2, 16'h5A5A);
        #1;
        chk(req_ready[0] == 1'b1, "R9 writer accepted", int'(req_ready[0]), 1);
        @(posedge clk);
        @(negedge clk);
        req_valid[0] = 1'b0;
        drive(3, 1'b0, 2, 0);
        #1;
        while (!rsp_valid && n < 8) begin
            chk(req_ready == '0, "R9 stalled during walk", int'(req_ready), 0);
            n++;
            @(negedge clk);
            #1;
        end
        chk(n == 3, "R9 walk length", n, 3);
        chk_rsp("R9 grant", 0, 1'b1, 16'h5A5A, 4);
        chk(req_ready[3] == 1'b1, "R9 stalled request accepted", int'(req_ready[3]), 1);
        @(posedge clk);
        @(negedge clk);
        req_valid[3] = 1'b0;
        #1;
        chk_rsp("R9 R7 stalled read", 3, 1'b0, 16'h5A5A, 0);
    endtask

    task automatic t_priority();
        @(negedge clk);
        drive(1, 1'b0, 7, 0);
        drive(2, 1'b0, 7, 0);
        #1;
        chk(req_ready == 4'b0010, "R10 lowest port wins", int'(req_ready), 2);
        @(posedge clk);
        @(negedge clk);
        req_valid[1] = 1'b0;
        #1;
        chk_rsp("R10 first served", 1, 1'b0, 0, 4);
        chk(req_ready == 4'b0100, "R10 second port next", int'(req_ready), 4);
        @(posedge clk);
        @(negedge clk);
        req_valid[2] = 1'b0;
        #1;
        chk_rsp("R10 R3 second served", 2, 1'b0, 0, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_chain_build();
        t_resharer();
        t_walk_and_after();
        t_unshared_write();
        t_stall();
        t_priority();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule